// File: doc/BRIEF.md
# Display Transmitter Interrupt Aggregator

The block gathers single-cycle event pulses from a display transmitter's link, DDC, content-protection, packet and video logic into three sticky 8-bit status registers. Three enable-mask registers choose which captured events raise the interrupt pin. The pin's active level and its drive style can be set in software. Two clear registers, whose bit order differs from the status order, clear chosen events. Each status register also accepts write-one-to-clear. A live system-status register shows the interrupt state and the hot-plug, receiver-sense and video-stable input levels.

Software reaches the block through a plain 8-bit address/data register bus. Writes are sampled on the clock edge and reads are combinational. The serial slave front end that drives this bus sits outside the block.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status, mask and control bit reads 0. The interrupt is inactive, `irq_o` is 1 (active-low idle) and `irq_oe_o` is 1.
- R2: An event pulse sets its status bit one edge later. Status A (0x06) is implemented on bits 0,1,2,4,5,7. Status B (0x07) is implemented on bits 0..6. Status C (0x08) is implemented on bits 0..6. Unimplemented bits read 0.
- R3: A captured status bit stays set, with no further events, until it is cleared.
- R4: Writing register 0x0C clears status bits as follows. Bits 1:0 clear status A bits 1:0. Bits 7:2 clear status B bits 5:0. A 0 written to any bit has no effect.
- R5: Writing register 0x0D clears status bits as follows. Bit 0 clears status B bit 6. Bits 7:2 clear status C bits 5:0. Bit 1 has no effect.
- R6: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Writing 1s to a status address clears those bits. Writing bit 1 of 0x0E clears status C bit 6.
- R8: Masks 0x09 and 0x0A line up bit for bit with status A and B. The interrupt is active when any status bit is set and its mask bit is 1.
- R9: Mask 0x0B bit k gates status C bit k+1, for k = 0..5. Status C bit 0 never raises the interrupt. Mask 0x0B reads back only bits 5:0.
- R10: Control 0x05 bit 7 selects the pin level: 1 for active-high, 0 for active-low. Bit 6 selects the drive style. With bit 6 at 0 (push-pull), `irq_oe_o` is always 1. With bit 6 at 1 (open-drain), `irq_oe_o` is 1 only while the interrupt is active.
- R11: Reading 0x0E returns the interrupt-active flag on bit 7, the hot-plug level on bit 6, the receiver-sense level on bit 5 and the video-stable level on bit 4. All other bits read 0.
- R12: Register 0x05 reads back only bits 7:6. Masks 0x09 and 0x0A read back only their implemented bits. Clear registers 0x0C and 0x0D read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| evt_a_i | input | 8 | Event pulses, status A layout |
| evt_b_i | input | 8 | Event pulses, status B layout |
| evt_c_i | input | 8 | Event pulses, status C layout |
| hpd_lvl_i | input | 1 | Hot-plug level |
| rxsense_lvl_i | input | 1 | Receiver-sense level |
| vid_stable_i | input | 1 | Transmit video stable level |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The status-register assertions assume that event and clear vectors are sampled on the clock edge and are held steady between edges. They relate one cycle's set and clear vectors to the next cycle's status, so they assume nothing about pulse width. The bench changes events and bus signals only on the falling edge and drops them one cycle later. It drives unimplemented event bits as well, to show that they are never captured.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int unsigned DW    = 8;
  parameter int unsigned AW    = 8;
  parameter int unsigned NSTAT = 3;

  localparam logic [AW-1:0] A_CTRL  = 8'h05;
  localparam logic [AW-1:0] A_STAT0 = 8'h06;
  localparam logic [AW-1:0] A_MASK0 = 8'h09;
  localparam logic [AW-1:0] A_CLRA  = 8'h0C;
  localparam logic [AW-1:0] A_CLRB  = 8'h0D;
  localparam logic [AW-1:0] A_SYS   = 8'h0E;

  // implemented bits per status register, index 0 = status A
  localparam logic [NSTAT-1:0][DW-1:0] STAT_IMPL = {8'h7F, 8'h7F, 8'hB7};
  // implemented bits per mask register (mask C is shifted down one)
  localparam logic [NSTAT-1:0][DW-1:0] MASK_IMPL = {8'h3F, 8'h7F, 8'hB7};

  localparam int unsigned CTRL_POL_BIT = 7;
  localparam int unsigned CTRL_OD_BIT  = 6;
  localparam int unsigned SYS_CTS_CLR  = 1;
endpackage

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
  parameter int unsigned        W    = 8,
  parameter logic [W-1:0]       IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= ((stat_q & ~clr_i) | set_i) & IMPL;
  end

  assign stat_o = stat_q;

  AST_EVENT_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & IMPL)) |=> ((stat_q & $past(set_i & IMPL)) == $past(set_i & IMPL))); // R2
  AST_STATUS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(stat_q)); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((stat_q & $past(clr_i & ~set_i)) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & clr_i & IMPL)) |=> ((stat_q & $past(set_i & clr_i & IMPL)) == $past(set_i & clr_i & IMPL))); // R6
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_agg_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [DW-1:0]              wdata_i,
  input  logic [NSTAT-1:0][DW-1:0]   stat_i,
  input  logic [DW-1:0]              sys_i,
  output logic [DW-1:0]              rdata_o,
  output logic [NSTAT-1:0][DW-1:0]   mask_o,
  output logic [NSTAT-1:0][DW-1:0]   clr_o,
  output logic                       pol_o,
  output logic                       od_o
);
  logic [NSTAT-1:0][DW-1:0] mask_q;
  logic                     pol_q, od_q;
  logic [DW-1:0]            clra, clrb, sysw;
  logic [NSTAT-1:0][DW-1:0] w1c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= 1'b0;
      od_q  <= 1'b0;
    end else if (we_i && addr_i == A_CTRL) begin
      pol_q <= wdata_i[CTRL_POL_BIT];
      od_q  <= wdata_i[CTRL_OD_BIT];
    end
  end

  for (genvar g = 0; g < NSTAT; g++) begin : g_mask
    localparam logic [AW-1:0] MADDR = A_MASK0 + AW'(g);
    localparam logic [AW-1:0] SADDR = A_STAT0 + AW'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       mask_q[g] <= '0;
      else if (we_i && addr_i == MADDR)  mask_q[g] <= wdata_i & MASK_IMPL[g];
    end
    assign w1c[g] = (we_i && addr_i == SADDR) ? wdata_i : '0;
  end

  assign clra = (we_i && addr_i == A_CLRA) ? wdata_i : '0;
  assign clrb = (we_i && addr_i == A_CLRB) ? wdata_i : '0;
  assign sysw = (we_i && addr_i == A_SYS)  ? wdata_i : '0;

  // clear registers are laid out differently from the status registers
  always_comb begin
    clr_o[0] = w1c[0] | {6'b0, clra[1:0]};
    clr_o[1] = w1c[1] | {1'b0, clrb[0], clra[7:2]};
    clr_o[2] = w1c[2] | {1'b0, sysw[SYS_CTS_CLR], clrb[7:2]};
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o[CTRL_POL_BIT] = pol_q;
      rdata_o[CTRL_OD_BIT]  = od_q;
    end else if (addr_i == A_SYS) begin
      rdata_o = sys_i;
    end
    for (int i = 0; i < NSTAT; i++) begin
      if (addr_i == A_STAT0 + AW'(i)) rdata_o = stat_i[i];
      if (addr_i == A_MASK0 + AW'(i)) rdata_o = mask_q[i];
    end
  end

  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign od_o   = od_q;
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic pol_i,
  input  logic od_i,
  output logic pin_o,
  output logic oe_o
);
  assign pin_o = pol_i ? active_i : ~active_i;
  assign oe_o  = od_i ? active_i : 1'b1;

  AST_PIN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (pin_o == pol_i)); // R10
  AST_OD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_i && !active_i) |-> !oe_o); // R10
  AST_PP_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !od_i |-> oe_o); // R10
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [7:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic [7:0]    evt_a_i,
  input  logic [7:0]    evt_b_i,
  input  logic [7:0]    evt_c_i,
  input  logic          hpd_lvl_i,
  input  logic          rxsense_lvl_i,
  input  logic          vid_stable_i,
  output logic          irq_o,
  output logic          irq_oe_o
);
  logic [NSTAT-1:0][DW-1:0] evt, stat, mask, clr;
  logic                     pol, od, irq_active;
  logic [DW-1:0]            sys;

  assign evt = {evt_c_i, evt_b_i, evt_a_i};

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    irq_stat_reg #(.W(DW), .IMPL(STAT_IMPL[g])) u_stat (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt[g]),
      .clr_i (clr[g]),
      .stat_o(stat[g])
    );
  end

  // mask C sits one bit below its status bit; status C bit 0 has no mask
  assign irq_active = |(stat[0] & mask[0]) | |(stat[1] & mask[1])
                    | |(stat[2][DW-2:1] & mask[2][DW-3:0]);

  assign sys = {irq_active, hpd_lvl_i, rxsense_lvl_i, vid_stable_i, 4'b0};

  irq_cfg_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .stat_i (stat),
    .sys_i  (sys),
    .rdata_o(reg_rdata_o),
    .mask_o (mask),
    .clr_o  (clr),
    .pol_o  (pol),
    .od_o   (od)
  );

  irq_pin_drv u_pin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(irq_active),
    .pol_i   (pol),
    .od_i    (od),
    .pin_o   (irq_o),
    .oe_o    (irq_oe_o)
  );

  AST_UNMASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_active); // R8
endmodule

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/100ps
module irq_aggregator_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [7:0] ea = '0, eb = '0, ec = '0;
  logic       hpd = 1'b0, rxs = 1'b0, vst = 1'b0;
  logic       irq, irq_oe;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_a_i(ea), .evt_b_i(eb),
    .evt_c_i(ec), .hpd_lvl_i(hpd), .rxsense_lvl_i(rxs), .vid_stable_i(vst),
    .irq_o(irq), .irq_oe_o(irq_oe)
  );

  typedef struct packed {
    logic [23:0] ev;   // {C,B,A}
    logic [7:0]  ca;
    logic [7:0]  cd;
    logic [23:0] exp;  // {C,B,A}
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{24'h0000FF, 8'h0C, 8'h00, 24'h0000B7},  // R2 layout A, R4 zero write
    '{24'h00FF00, 8'h0D, 8'h00, 24'h007F00},  // R2 layout B
    '{24'hFF0000, 8'h0C, 8'h00, 24'h7F0000},  // R2 layout C
    '{24'h003F03, 8'h0C, 8'hFF, 24'h000000},  // R4
    '{24'h3F4000, 8'h0D, 8'hFF, 24'h000000},  // R5
    '{24'h000003, 8'h0C, 8'h01, 24'h000002},  // R4
    '{24'h7F0000, 8'h0D, 8'h84, 24'h5E0000},  // R5
    '{24'h007F00, 8'h0D, 8'h01, 24'h003F00},  // R5
    '{24'h0000B7, 8'h0C, 8'h02, 24'h0000B5},  // R4
    '{24'h400000, 8'h0C, 8'hFF, 24'h400000}   // R4 leaves C bit6
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    @(negedge clk); ea = a; eb = b; ec = c;
    @(negedge clk); ea = '0; eb = '0; ec = '0;
  endtask

  task automatic wipe();
    wr(8'h06, 8'hFF); wr(8'h07, 8'hFF); wr(8'h08, 8'hFF);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 5; a <= 14; a++) begin
      rd(8'(a), d); chk("R1 reset read", d, 8'h00);
    end
    chk("R1 pin idle", {7'b0, irq}, 8'h01);
    chk("R1 oe idle", {7'b0, irq_oe}, 8'h01);

    // table walk: events, one clear write, read all status
    for (int i = 0; i < NV; i++) begin
      pulse(VECS[i].ev[7:0], VECS[i].ev[15:8], VECS[i].ev[23:16]);
      wr(VECS[i].ca, VECS[i].cd);
      for (int s = 0; s < 3; s++) begin
        rd(8'h06 + 8'(s), d);
        chk($sformatf("R2/R4/R5 vector %0d reg %0d", i, s), d, VECS[i].exp[s*8 +: 8]);
      end
      wipe();
    end

    // R3 sticky
    pulse(8'h01, 8'h00, 8'h00);
    repeat (6) @(negedge clk);
    rd(8'h06, d); chk("R3 sticky", d, 8'h01);
    wipe();

    // R6 event and clear in the same cycle
    @(negedge clk); ea = 8'h01; we = 1'b1; addr = 8'h0C; wdata = 8'h01;
    @(negedge clk); ea = '0; we = 1'b0; addr = '0; wdata = '0;
    rd(8'h06, d); chk("R6 set wins", d, 8'h01);
    wipe();

    // R7 status write-one-to-clear and audio CTS clear via 0x0E
    pulse(8'h30, 8'h00, 8'h40);
    wr(8'h06, 8'h10);
    rd(8'h06, d); chk("R7 w1c partial", d, 8'h20);
    wr(8'h0E, 8'h02);
    rd(8'h08, d); chk("R7 cts clear", d, 8'h00);
    wipe();

    // R8 mask gating
    pulse(8'h01, 8'h00, 8'h00);
    rd(8'h0E, d); chk("R8 masked off", d, 8'h00);
    wr(8'h09, 8'h01);
    rd(8'h0E, d); chk("R8 active flag", d, 8'h80);
    chk("R8 pin active-low", {7'b0, irq}, 8'h00);
    wr(8'h09, 8'h00); wr(8'h0A, 8'h40);
    pulse(8'h00, 8'h40, 8'h00);
    rd(8'h0E, d); chk("R8 mask B bit6", d, 8'h80);
    wr(8'h0A, 8'h00); wipe();

    // R9 mask C offset
    wr(8'h0B, 8'h3F);
    pulse(8'h00, 8'h00, 8'h01);
    rd(8'h0E, d); chk("R9 status C bit0 never irq", d, 8'h00);
    wipe();
    wr(8'h0B, 8'h02);
    pulse(8'h00, 8'h00, 8'h02);
    rd(8'h0E, d); chk("R9 unaligned mask no irq", d, 8'h00);
    wr(8'h0B, 8'h01);
    rd(8'h0E, d); chk("R9 mask bit0 gates status bit1", d, 8'h80);
    wr(8'h0B, 8'h00); wipe();

    // R10 polarity and drive mode
    wr(8'h09, 8'h01);
    pulse(8'h01, 8'h00, 8'h00);
    chk("R10 active-low pin", {6'b0, irq, irq_oe}, 8'h01);
    wr(8'h05, 8'h80);
    chk("R10 active-high pin", {6'b0, irq, irq_oe}, 8'h03);
    wr(8'h05, 8'hC0);
    chk("R10 od driven while active", {6'b0, irq, irq_oe}, 8'h03);
    wr(8'h0C, 8'h01);
    chk("R10 od released", {6'b0, irq, irq_oe}, 8'h00);
    wr(8'h05, 8'h40);
    chk("R10 od active-low idle", {6'b0, irq, irq_oe}, 8'h02);
    wr(8'h05, 8'h00); wr(8'h09, 8'h00);

    // R11 live levels
    @(negedge clk); hpd = 1'b1; rxs = 1'b0; vst = 1'b1;
    rd(8'h0E, d); chk("R11 levels", d, 8'h50);
    @(negedge clk); hpd = 1'b0; rxs = 1'b1; vst = 1'b0;
    rd(8'h0E, d); chk("R11 levels alt", d, 8'h20);
    rxs = 1'b0;

    // R12 read-back widths
    wr(8'h05, 8'hFF); rd(8'h05, d); chk("R12 ctrl", d, 8'hC0);
    wr(8'h09, 8'hFF); rd(8'h09, d); chk("R12 mask A", d, 8'hB7);
    wr(8'h0A, 8'hFF); rd(8'h0A, d); chk("R12 mask B", d, 8'h7F);
    wr(8'h0B, 8'hFF); rd(8'h0B, d); chk("R9 R12 mask C", d, 8'h3F);
    rd(8'h0C, d); chk("R12 clear A reads 0", d, 8'h00);
    rd(8'h0D, d); chk("R12 clear B reads 0", d, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule